// File: doc/BRIEF.md
# Program Memory Lock Guard

This block protects the on-chip program store of a small microcontroller. It owns the code byte array, a 32-byte scrambling key and two lock bits. It serves three kinds of access. The first is the programming port, which writes code bytes, key bytes or lock bits and can wipe everything with one erase. The second is the verify path, which returns each code byte XNORed with the key byte picked by the five low address bits. The third is the runtime table-read path, which the processor core uses to read constants out of code space.

Programming the first lock bit is the basic protection level. It blocks further code and key writes and keeps table reads issued from external code away from internal bytes. Programming both lock bits also blanks verify. The pairing in which only the second bit is programmed is reserved, and the block treats it as fully open. The external-access pin is captured while reset is held, and a flag reports whenever the live pin drifts from that captured copy. With the signature select raised, two fixed identification bytes appear at addresses 30h and 31h.

Top module: `code_lock_guard`

## Requirements
- R1: A one-cycle `pgm_erase` sets every code byte, every key byte and both lock bits to all ones, which leaves the block fully open. Erase takes priority over a write in the same cycle.
- R2: `vfy_data` is registered. One cycle after `pgm_addr` is presented, it equals the code byte at that address XNOR the key byte selected by `pgm_addr[4:0]`.
- R3: While the selected key byte is all ones, verify returns the stored code byte unchanged.
- R4: The lock word is written with `pgm_space`=2, and bit 0 of that word is the first lock bit (0 = programmed). While the first lock bit is programmed, code writes (`pgm_space`=0) and key writes (`pgm_space`=1) are refused, verify keeps working, and lock writes are still accepted.
- R5: While both lock bits are programmed, `vfy_data` reads FFh for every address, signature addresses included.
- R6: The second lock bit is bit 1 of the lock word. When it is programmed on its own, the block behaves exactly as if fully open: writes land, verify works and no table read is blocked.
- R7: A table read (`rd_req`) gives `rd_valid` one cycle later, with `rd_data` equal to the plain code byte. When the first lock bit is programmed and `rd_from_ext` is high, `rd_data` is FFh instead and `rd_violation` pulses for that one cycle. With no request, `rd_valid`, `rd_violation` and `rd_data` are zero.
- R8: Key and lock writes can only clear bits: the new value is the old value AND the write data. Only an erase returns bits to 1.
- R9: `ea_latched` takes `ea_pin` on every clock where reset is high and holds it otherwise. `ea_mismatch` is high whenever `ea_pin` differs from `ea_latched`.
- R10: With `pgm_sig` high and verify not blanked, a verify at 30h returns 89h, and a verify at 31h returns 51h (SIG_VARIANT=0) or 52h (SIG_VARIANT=1). Other addresses verify normally.
- R11: While reset is high, `vfy_data` is FFh and `rd_valid`, `rd_violation` and `rd_data` are zero. Stored code, key and lock contents persist across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_addr | input | ADDR_W | Programming / verify address |
| pgm_wdata | input | 8 | Programming write data |
| pgm_space | input | 2 | Write target: 0 code, 1 key, 2 lock word, 3 none |
| pgm_wr | input | 1 | Program strobe |
| pgm_erase | input | 1 | Erase everything to all ones |
| pgm_sig | input | 1 | Signature select for verify |
| vfy_data | output | 8 | Registered verify data |
| rd_req | input | 1 | Runtime table-read request |
| rd_addr | input | ADDR_W | Table-read address |
| rd_from_ext | input | 1 | Request issued by code running from external memory |
| ea_pin | input | 1 | Live external-access pin |
| rd_data | output | 8 | Table-read data |
| rd_valid | output | 1 | Table-read data valid |
| rd_violation | output | 1 | One-cycle pulse when a table read is blocked |
| ea_latched | output | 1 | External-access value captured during reset |
| ea_mismatch | output | 1 | Live pin differs from the captured value |

## Verification
Each verify and each table read comes back exactly one clock after its inputs are sampled. A write or erase shows in verify data only when the address is sampled after the writing edge, so that result arrives two edges after the strobe. The mismatch flag is combinational and changes in the same cycle as the pin. The bench steps a behavioural model at every rising edge, computing the expected registered outputs from the model state before it applies that edge's writes. It compares at the following falling edge, so every check sits in the cycle where the registered output has just settled.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

    localparam int KEY_BYTES = 32;
    localparam int KEY_IDX_W = $clog2(KEY_BYTES);
    localparam int BYTE_W    = 8;

    localparam logic [7:0] SIG_MAKER  = 8'h89;
    localparam logic [7:0] SIG_DEV_A  = 8'h51;
    localparam logic [7:0] SIG_DEV_B  = 8'h52;
    localparam int         SIG_ADDR_0 = 'h30;
    localparam int         SIG_ADDR_1 = 'h31;

    typedef enum logic [1:0] {
        SP_CODE = 2'd0,
        SP_KEY  = 2'd1,
        SP_LOCK = 2'd2,
        SP_NONE = 2'd3
    } pgm_space_e;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'd0,
        LVL_NOPGM = 2'd1,
        LVL_NOVFY = 2'd2
    } lock_lvl_e;

    // 1 = unprogrammed
    typedef struct packed {
        logic lb2;
        logic lb1;
    } lock_bits_t;

    typedef struct packed {
        logic       valid;
        logic       viol;
        logic [7:0] data;
    } rd_resp_t;

    function automatic lock_lvl_e decode_level(input lock_bits_t b);
        if (!b.lb1 && !b.lb2) return LVL_NOVFY;
        if (!b.lb1)           return LVL_NOPGM;
        return LVL_OPEN;   // reserved pairing treated as open
    endfunction

    function automatic logic [7:0] scramble(input logic [7:0] code_b, input logic [7:0] key_b);
        return ~(code_b ^ key_b);
    endfunction

    function automatic logic [7:0] device_sig(input int variant);
        return (variant == 0) ? SIG_DEV_A : SIG_DEV_B;
    endfunction

endpackage

// File: rtl/code_store.sv
module code_store
    import code_lock_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [7:0]        vdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign vdata = mem_q[vaddr];
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/key_store.sv
module key_store
    import code_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 erase,
    input  logic                 key_we,
    input  logic                 lock_we,
    input  logic [KEY_IDX_W-1:0] idx,
    input  logic [7:0]           wdata,
    output logic [7:0]           key_byte,
    output lock_bits_t           lock_q
);
    logic [7:0] key_q [KEY_BYTES];

    generate
        for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
            always_ff @(posedge clk) begin
                if (erase)
                    key_q[g] <= 8'hFF;
                else if (key_we && idx == KEY_IDX_W'(g))
                    key_q[g] <= key_q[g] & wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (erase)
            lock_q <= '{lb2: 1'b1, lb1: 1'b1};
        else if (lock_we)
            lock_q <= lock_q & lock_bits_t'(wdata[1:0]);
    end

    assign key_byte = key_q[idx];

endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
    import code_lock_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SIG_VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  lock_bits_t        lock_q,
    input  logic [1:0]        pgm_space,
    input  logic              pgm_wr,
    input  logic              pgm_erase,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic              pgm_sig,
    input  logic [7:0]        code_vbyte,
    input  logic [7:0]        key_vbyte,
    input  logic              rd_req,
    input  logic              rd_from_ext,
    input  logic [7:0]        code_rbyte,
    output logic              code_we,
    output logic              key_we,
    output logic              lock_we,
    output logic [7:0]        vfy_data,
    output rd_resp_t          rd_resp
);
    localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(SIG_ADDR_0);
    localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(SIG_ADDR_1);
    localparam logic [7:0]        DEV_SIG = device_sig(SIG_VARIANT);

    lock_lvl_e  level;
    pgm_space_e space;
    logic       wr_ok;
    logic [7:0] vfy_next;
    logic       rd_block;

    assign level = decode_level(lock_q);
    assign space = pgm_space_e'(pgm_space);
    assign wr_ok = pgm_wr && !pgm_erase;

    assign code_we = wr_ok && (space == SP_CODE) && (level == LVL_OPEN);
    assign key_we  = wr_ok && (space == SP_KEY)  && (level == LVL_OPEN);
    assign lock_we = wr_ok && (space == SP_LOCK);

    always_comb begin
        if (level == LVL_NOVFY)
            vfy_next = 8'hFF;
        else if (pgm_sig && pgm_addr == SIG_A0)
            vfy_next = SIG_MAKER;
        else if (pgm_sig && pgm_addr == SIG_A1)
            vfy_next = DEV_SIG;
        else
            vfy_next = scramble(code_vbyte, key_vbyte);
    end

    assign rd_block = (level != LVL_OPEN) && rd_from_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            vfy_data <= 8'hFF;
            rd_resp  <= '0;
        end else begin
            vfy_data      <= vfy_next;
            rd_resp.valid <= rd_req;
            rd_resp.viol  <= rd_req && rd_block;
            rd_resp.data  <= !rd_req ? 8'h00 : (rd_block ? 8'hFF : code_rbyte);
        end
    end

endmodule

// File: rtl/code_lock_guard.sv
module code_lock_guard
    import code_lock_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SIG_VARIANT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [7:0]        pgm_wdata,
    input  logic [1:0]        pgm_space,
    input  logic              pgm_wr,
    input  logic              pgm_erase,
    input  logic              pgm_sig,
    output logic [7:0]        vfy_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_from_ext,
    input  logic              ea_pin,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              rd_violation,
    output logic              ea_latched,
    output logic              ea_mismatch
);
    lock_bits_t lock_q;
    logic       code_we, key_we, lock_we;
    logic [7:0] code_vbyte, code_rbyte, key_vbyte;
    rd_resp_t   rd_resp;

    code_store #(.ADDR_W(ADDR_W)) u_code (
        .clk   (clk),
        .erase (pgm_erase),
        .we    (code_we),
        .waddr (pgm_addr),
        .wdata (pgm_wdata),
        .vaddr (pgm_addr),
        .vdata (code_vbyte),
        .raddr (rd_addr),
        .rdata (code_rbyte)
    );

    key_store u_keys (
        .clk      (clk),
        .erase    (pgm_erase),
        .key_we   (key_we),
        .lock_we  (lock_we),
        .idx      (pgm_addr[KEY_IDX_W-1:0]),
        .wdata    (pgm_wdata),
        .key_byte (key_vbyte),
        .lock_q   (lock_q)
    );

    access_ctrl #(.ADDR_W(ADDR_W), .SIG_VARIANT(SIG_VARIANT)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .lock_q      (lock_q),
        .pgm_space   (pgm_space),
        .pgm_wr      (pgm_wr),
        .pgm_erase   (pgm_erase),
        .pgm_addr    (pgm_addr),
        .pgm_sig     (pgm_sig),
        .code_vbyte  (code_vbyte),
        .key_vbyte   (key_vbyte),
        .rd_req      (rd_req),
        .rd_from_ext (rd_from_ext),
        .code_rbyte  (code_rbyte),
        .code_we     (code_we),
        .key_we      (key_we),
        .lock_we     (lock_we),
        .vfy_data    (vfy_data),
        .rd_resp     (rd_resp)
    );

    always_ff @(posedge clk) begin
        if (rst) ea_latched <= ea_pin;
    end

    assign ea_mismatch  = ea_pin ^ ea_latched;
    assign rd_data      = rd_resp.data;
    assign rd_valid     = rd_resp.valid;
    assign rd_violation = rd_resp.viol;

endmodule

module code_lock_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       pgm_erase,
    input logic [1:0] lock_q,
    input logic       code_we,
    input logic [7:0] vfy_data,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       rd_violation,
    input logic       ea_latched
);
    a_r1_erase_unlocks: assert property (@(posedge clk) disable iff (rst)
        pgm_erase |=> (lock_q == 2'b11));

    a_r4_code_write_refused: assert property (@(posedge clk) disable iff (rst)
        !lock_q[0] |-> !code_we);

    a_r5_verify_blanked: assert property (@(posedge clk) disable iff (rst)
        (lock_q == 2'b00) |=> (vfy_data == 8'hFF));

    a_r7_violation_shape: assert property (@(posedge clk) disable iff (rst)
        rd_violation |-> (rd_valid && rd_data == 8'hFF));

    a_r8_lock_clear_only: assert property (@(posedge clk) disable iff (rst)
        !pgm_erase |=> ((lock_q & ~$past(lock_q)) == 2'b00));

    a_r9_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(ea_latched));
endmodule

bind code_lock_guard code_lock_guard_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pgm_erase    (pgm_erase),
    .lock_q       (lock_q),
    .code_we      (code_we),
    .vfy_data     (vfy_data),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_violation (rd_violation),
    .ea_latched   (ea_latched)
);

// File: tb/code_lock_guard_tb.sv
module code_lock_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] pgm_addr = '0;
    logic [7:0]    pgm_wdata = '0;
    logic [1:0]    pgm_space = 2'd3;
    logic          pgm_wr = 1'b0, pgm_erase = 1'b0, pgm_sig = 1'b0;
    logic          rd_req = 1'b0, rd_from_ext = 1'b0, ea_pin = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    vfy_data, rd_data;
    logic          rd_valid, rd_violation, ea_latched, ea_mismatch;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    code_lock_guard #(.ADDR_W(AW), .SIG_VARIANT(0)) dut_i (
        .clk(clk), .rst(rst), .pgm_addr(pgm_addr), .pgm_wdata(pgm_wdata),
        .pgm_space(pgm_space), .pgm_wr(pgm_wr), .pgm_erase(pgm_erase),
        .pgm_sig(pgm_sig), .vfy_data(vfy_data), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_from_ext(rd_from_ext), .ea_pin(ea_pin),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_violation(rd_violation),
        .ea_latched(ea_latched), .ea_mismatch(ea_mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] code_m [256];
    logic [7:0] key_m  [32];
    logic [1:0] lb_m = 2'b11;      // bit0 first lock bit, bit1 second; 0 = programmed
    logic       ea_m = 1'b0;
    bit         model_ok = 0, started = 0, e_ok = 0;
    logic [7:0] e_vfy, e_rdd;
    logic       e_rdv, e_viol;
    string      vtag;

    always @(posedge clk) begin
        started <= 1;
        e_ok = model_ok;
        if (rst) begin
            e_vfy = 8'hFF; e_rdv = 0; e_viol = 0; e_rdd = 8'h00; vtag = "R11";
            ea_m = ea_pin;
        end else begin
            if (lb_m == 2'b00) begin
                e_vfy = 8'hFF; vtag = "R5";
            end else if (pgm_sig && pgm_addr == 8'h30) begin
                e_vfy = 8'h89; vtag = "R10";
            end else if (pgm_sig && pgm_addr == 8'h31) begin
                e_vfy = 8'h51; vtag = "R10";
            end else begin
                e_vfy = ~(code_m[pgm_addr] ^ key_m[pgm_addr[4:0]]); vtag = "R2";
            end
            e_rdv  = rd_req;
            e_viol = rd_req && !lb_m[0] && rd_from_ext;
            e_rdd  = !rd_req ? 8'h00 : (e_viol ? 8'hFF : code_m[rd_addr]);
        end
        if (pgm_erase) begin
            for (int i = 0; i < 256; i++) code_m[i] = 8'hFF;
            for (int i = 0; i < 32; i++) key_m[i] = 8'hFF;
            lb_m = 2'b11;
            model_ok = 1;
        end else if (pgm_wr) begin
            if (pgm_space == 2'd0 && lb_m[0]) code_m[pgm_addr] = pgm_wdata;
            if (pgm_space == 2'd1 && lb_m[0]) key_m[pgm_addr[4:0]] = key_m[pgm_addr[4:0]] & pgm_wdata;
            if (pgm_space == 2'd2) lb_m = lb_m & pgm_wdata[1:0];
        end
    end

    always @(negedge clk) begin
        if (started) begin
            if (e_ok || rst) check(vtag, vfy_data, e_vfy);
            check("R7 valid", {7'd0, rd_valid}, {7'd0, e_rdv});
            check("R7 violation", {7'd0, rd_violation}, {7'd0, e_viol});
            if (e_ok || rst) check("R7 data", rd_data, e_rdd);
            check("R9 latched", {7'd0, ea_latched}, {7'd0, ea_m});
            check("R9 mismatch", {7'd0, ea_mismatch}, {7'd0, ea_pin != ea_m});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic prog(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pgm_space = sp; pgm_addr = a; pgm_wdata = d; pgm_wr = 1'b1;
        @(negedge clk);
        pgm_wr = 1'b0; pgm_space = 2'd3;
    endtask

    task automatic erase_all();
        @(negedge clk);
        pgm_erase = 1'b1;
        @(negedge clk);
        pgm_erase = 1'b0;
    endtask

    task automatic vfy(input logic [7:0] a, input logic sig, input logic [7:0] exp, input string tag);
        @(negedge clk);
        pgm_addr = a; pgm_sig = sig;
        @(posedge clk);
        @(negedge clk);
        check(tag, vfy_data, exp);
        pgm_sig = 1'b0;
    endtask

    task automatic tread(input logic [7:0] a, input logic ext, input logic [7:0] exp, input logic viol, input string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_from_ext = ext;
        @(posedge clk);
        @(negedge clk);
        check(tag, rd_data, exp);
        check(tag, {7'd0, rd_violation}, {7'd0, viol});
        rd_req = 1'b0; rd_from_ext = 1'b0;
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset vfy", vfy_data, 8'hFF);
        check("R11 reset valid", {7'd0, rd_valid}, 8'h00);
        check("R9 reset latch", {7'd0, ea_latched}, 8'h01);
        rst = 1'b0;

        erase_all();
        vfy(8'h44, 1'b0, 8'hFF, "R1 erased code");
        prog(2'd0, 8'h10, 8'h5A);
        prog(2'd0, 8'h11, 8'hC3);
        prog(2'd0, 8'h30, 8'h77);
        vfy(8'h10, 1'b0, 8'h5A, "R3 plain verify");
        vfy(8'h30, 1'b1, 8'h89, "R10 maker byte");
        vfy(8'h31, 1'b1, 8'h51, "R10 device byte");
        vfy(8'h30, 1'b0, 8'h77, "R10 sig off");
        prog(2'd1, 8'h10, 8'hA5);
        vfy(8'h10, 1'b0, 8'h00, "R2 keyed verify");
        vfy(8'h30, 1'b0, 8'h2D, "R2 shared key byte");
        prog(2'd1, 8'h10, 8'h0F);
        vfy(8'h10, 1'b0, 8'hA0, "R8 key clear only");
        tread(8'h11, 1'b0, 8'hC3, 1'b0, "R7 internal open");
        tread(8'h11, 1'b1, 8'hC3, 1'b0, "R7 external open");

        prog(2'd2, 8'h00, 8'h01);            // second lock bit only
        prog(2'd0, 8'h20, 8'h12);
        vfy(8'h20, 1'b0, 8'h12, "R6 reserved open write");
        tread(8'h20, 1'b1, 8'h12, 1'b0, "R6 reserved open read");

        erase_all();
        vfy(8'h20, 1'b0, 8'hFF, "R1 erase after lock");
        prog(2'd0, 8'h20, 8'h12);
        prog(2'd2, 8'h00, 8'h02);            // first lock bit only
        prog(2'd0, 8'h20, 8'h99);
        vfy(8'h20, 1'b0, 8'h12, "R4 code write refused");
        prog(2'd1, 8'h20, 8'h00);
        vfy(8'h20, 1'b0, 8'h12, "R4 key write refused");
        tread(8'h20, 1'b1, 8'hFF, 1'b1, "R7 external blocked");
        tread(8'h20, 1'b0, 8'h12, 1'b0, "R7 internal allowed");
        prog(2'd2, 8'h00, 8'h03);
        vfy(8'h20, 1'b0, 8'h12, "R8 lock not re-set");
        prog(2'd2, 8'h00, 8'h01);            // both programmed
        vfy(8'h20, 1'b0, 8'hFF, "R5 verify blank");
        vfy(8'h30, 1'b1, 8'hFF, "R5 signature blank");

        @(negedge clk);
        ea_pin = 1'b0;
        @(negedge clk);
        check("R9 mismatch live", {7'd0, ea_mismatch}, 8'h01);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 relatched", {7'd0, ea_latched}, 8'h00);
        check("R9 mismatch clear", {7'd0, ea_mismatch}, 8'h00);
        vfy(8'h20, 1'b0, 8'hFF, "R11 lock persists");
        erase_all();
        vfy(8'h20, 1'b0, 8'hFF, "R1 final erase");
        vfy(8'h31, 1'b1, 8'h51, "R10 after erase");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule